// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every data beat of one SDRAM burst. A start strobe captures a start column, a burst-length code and an ordering mode. From the next cycle on, the block outputs one column address per clock. It marks the final beat of a fixed-length burst with a flag. A memory model can use it to pick the word for each beat, and a controller can use it to track which word sits on each beat.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside an aligned group of columns. They step through that group either by counting upward with wrap-around or by XOR with the beat index. Full-page bursts step through every column of the row in ascending order and wrap. They run until a stop input ends them. A write issued while single-write mode is selected always lasts one beat.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o` and `last_o` are 0.
- R2: When `start_i` is high at a clock edge, `valid_o` is 1 in the following cycle and `col_o` equals the captured `col_i` (beat 0).
- R3: With `ilv_i`=0 and burst length N in {2,4,8}, beat i carries the low log2(N) bits equal to (start + i) mod N. The upper column bits keep the start value.
- R4: With `ilv_i`=1 and burst length N in {2,4,8}, beat i carries the low log2(N) bits equal to start XOR i. The upper column bits keep the start value.
- R5: The `bl_i` codes are 0=1 beat, 1=2, 2=4, 3=8 and 7=full page. `last_o` is 1 on exactly the final beat of a fixed-length burst, and `valid_o` falls in the next cycle unless a new start arrives.
- R6: Full page (code 7) steps through the columns in ascending order, modulo 256, from the start column. It ignores `ilv_i`, never raises `last_o`, and continues past 256 beats.
- R7: In a full-page burst, the beat during which `stop_i` is high at the clock edge is the final valid beat. `stop_i` has no effect on a fixed-length burst.
- R8: When `wr_i` and `single_wr_i` are both 1 at the start, the burst lasts exactly one beat with `last_o`=1, whatever the value of `bl_i`.
- R9: A start strobe during a running burst abandons it, and beat 0 of the new burst appears in the next cycle.
- R10: The `bl_i` codes 4, 5 and 6 behave as a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst start strobe |
| col_i | input | 8 | Start column |
| bl_i | input | 3 | Burst-length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| wr_i | input | 1 | Burst is a write |
| single_wr_i | input | 1 | Single-write mode selected |
| stop_i | input | 1 | Ends a full-page burst |
| valid_o | output | 1 | A beat address is present |
| col_o | output | 8 | Column address of the current beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The start strobe is captured at a clock edge. Its beat 0 is due on the outputs one cycle later, and every following beat is due one cycle after the one before. A stop or a restart takes effect in the cycle after the edge that samples it. The bench drives inputs on the falling edge. On the rising edge it advances a behavioural integer model of the burst. On every falling edge it compares `valid_o`, `col_o` and `last_o` with that model, so each result is checked in the cycle it is due.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int unsigned COL_W = 8;
  localparam int unsigned BL_W  = 3;

  typedef enum logic [BL_W-1:0] {
    BL_ONE  = 3'd0,
    BL_TWO  = 3'd1,
    BL_FOUR = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
#(
  parameter int unsigned W = COL_W
) (
  input  logic [BL_W-1:0] bl_i,
  input  logic            wr_i,
  input  logic            single_wr_i,
  output logic [W-1:0]    mask_o,
  output logic            full_o
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [1:0] log_len;
  logic       page;

  always_comb begin
    page    = 1'b0;
    log_len = 2'd0;
    case (bl_i)
      BL_TWO:   log_len = 2'd1;
      BL_FOUR:  log_len = 2'd2;
      BL_EIGHT: log_len = 2'd3;
      BL_PAGE:  page    = 1'b1;
      default:  log_len = 2'd0; // reserved codes act as one beat
    endcase
    if (wr_i && single_wr_i) begin
      page    = 1'b0;
      log_len = 2'd0;
    end
  end

  assign full_o = page;
  assign mask_o = page ? ONES : ~(ONES << log_len);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sdram_burst_pkg::*;
#(
  parameter int unsigned W = COL_W
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] beat_i,
  input  logic [W-1:0] mask_i,
  input  logic         ilv_i,
  input  logic         full_i,
  output logic [W-1:0] col_o,
  output logic         last_o
);
  logic [W-1:0] seq_col, ilv_col;

  assign seq_col = (base_i + beat_i) & mask_i;
  assign ilv_col = (base_i ^ beat_i) & mask_i;
  // full page is always sequential
  assign col_o   = (base_i & ~mask_i) | ((ilv_i && !full_i) ? ilv_col : seq_col);
  assign last_o  = !full_i && ((beat_i & mask_i) == mask_i);
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int unsigned W = COL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] col_i,
  input  logic [W-1:0] mask_i,
  input  logic         full_i,
  input  logic         ilv_i,
  input  logic         stop_i,
  input  logic         last_i,
  output logic         active_o,
  output logic [W-1:0] base_o,
  output logic [W-1:0] beat_o,
  output logic [W-1:0] mask_o,
  output logic         full_o,
  output logic         ilv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      base_o   <= '0;
      beat_o   <= '0;
      mask_o   <= '0;
      full_o   <= 1'b0;
      ilv_o    <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      base_o   <= col_i;
      beat_o   <= '0;
      mask_o   <= mask_i;
      full_o   <= full_i;
      ilv_o    <= ilv_i;
    end else if (active_o) begin
      if ((full_o && stop_i) || last_i) active_o <= 1'b0;
      else                              beat_o   <= beat_o + 1'b1;
    end
  end

  a_r6_no_last_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && full_o) |-> !last_i);
  a_r7_stop_ends_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && full_o && stop_i && !start_i) |=> !active_o);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_burst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BL_W-1:0]   bl_i,
  input  logic              ilv_i,
  input  logic              wr_i,
  input  logic              single_wr_i,
  input  logic              stop_i,
  output logic              valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic              last_o
);
  logic [COL_W-1:0] dec_mask, base_q, beat_q, mask_q, col_w;
  logic             dec_full, full_q, ilv_q, active_q, last_w;

  burst_len_decode #(.W(COL_W)) u_dec (
    .bl_i(bl_i), .wr_i(wr_i), .single_wr_i(single_wr_i),
    .mask_o(dec_mask), .full_o(dec_full)
  );

  burst_ctrl #(.W(COL_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .col_i(col_i),
    .mask_i(dec_mask), .full_i(dec_full), .ilv_i(ilv_i), .stop_i(stop_i),
    .last_i(last_w), .active_o(active_q), .base_o(base_q), .beat_o(beat_q),
    .mask_o(mask_q), .full_o(full_q), .ilv_o(ilv_q)
  );

  burst_addr_gen #(.W(COL_W)) u_addr (
    .base_i(base_q), .beat_i(beat_q), .mask_i(mask_q), .ilv_i(ilv_q),
    .full_i(full_q), .col_o(col_w), .last_o(last_w)
  );

  assign valid_o = active_q;
  assign col_o   = col_w;
  assign last_o  = active_q && last_w;

  a_r2_start_beat0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(col_i)));
  a_r5_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);
  a_r8_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && wr_i && single_wr_i) |=> last_o);
  a_r3_runs_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !stop_i && !start_i) |=> valid_o);
  a_r1_last_implies_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, ilv = 0, wr = 0, swr = 0, stop = 0;
  logic [7:0] col = 0;
  logic [2:0] bl = 0;
  logic valid, last;
  logic [7:0] col_q;

  int checks = 0, fails = 0, cycles = 0;
  string req = "R1";

  // behavioural model
  bit m_act = 0;
  int m_base = 0, m_i = 0, m_n = 1, m_ilv = 0;

  always #4 clk = ~clk;

  sdram_burst_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .col_i(col), .bl_i(bl),
    .ilv_i(ilv), .wr_i(wr), .single_wr_i(swr), .stop_i(stop),
    .valid_o(valid), .col_o(col_q), .last_o(last)
  );

  function automatic int exp_col();
    int lo;
    if (m_n == 0) return (m_base + m_i) % 256;
    lo = m_base % m_n;
    if (m_ilv != 0) return (m_base / m_n) * m_n + (lo ^ m_i);
    return (m_base / m_n) * m_n + ((lo + m_i) % m_n);
  endfunction

  function automatic bit exp_last();
    return m_act && m_n != 0 && m_i == m_n - 1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) m_act = 0;
    else if (start) begin
      m_act = 1; m_base = col; m_i = 0; m_ilv = ilv;
      case (bl)
        3'd1: m_n = 2; 3'd2: m_n = 4; 3'd3: m_n = 8; 3'd7: m_n = 0;
        default: m_n = 1;
      endcase
      if (wr && swr) m_n = 1;
      if (m_n == 0) m_ilv = 0;
    end else if (m_act) begin
      if ((m_n == 0 && stop) || exp_last()) m_act = 0;
      else m_i++;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("valid", valid, m_act);
    if (m_act) begin
      chk("col", col_q, exp_col());
      chk("last", last, exp_last());
    end else chk("last", last, 0);
  end

  task automatic go(int c, int b, bit il, bit w, bit s, string r);
    @(negedge clk);
    req = r; col = c[7:0]; bl = b[2:0]; ilv = il; wr = w; swr = s; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;  // R1 checked across reset and first cycle
    idle(2);
    go(8'h2E, 2, 0, 0, 0, "R3"); idle(6);         // 2E 2F 2C 2D
    go(8'hFD, 3, 0, 0, 0, "R3"); idle(10);
    go(8'h81, 1, 0, 0, 0, "R3"); idle(3);
    go(8'h45, 3, 1, 0, 0, "R4"); idle(10);        // 45 44 47 46 41 40 43 42
    go(8'h0E, 2, 1, 0, 0, "R4"); idle(6);
    go(8'h13, 1, 1, 0, 0, "R4"); idle(3);
    go(8'h77, 0, 0, 0, 0, "R5"); idle(3);
    go(8'h33, 3, 0, 0, 0, "R7");                  // stop ignored in fixed burst
    stop = 1; idle(9); stop = 0;
    go(8'hFC, 7, 1, 0, 0, "R6"); idle(270);       // wraps, ilv ignored
    req = "R7"; stop = 1; idle(1); stop = 0; idle(3);
    go(8'h10, 3, 0, 1, 1, "R8"); idle(3);
    go(8'h20, 7, 0, 1, 1, "R8"); idle(3);
    go(8'h10, 3, 0, 1, 0, "R8"); idle(10);        // write without single mode: full length
    go(8'h55, 4, 0, 0, 0, "R10"); idle(2);
    go(8'h56, 5, 1, 0, 0, "R10"); idle(2);
    go(8'h57, 6, 0, 0, 0, "R10"); idle(2);
    go(8'h60, 3, 0, 0, 0, "R9"); idle(2);
    go(8'h9A, 2, 1, 0, 0, "R9"); idle(6);
    go(8'hA0, 7, 0, 0, 0, "R9"); idle(3);
    go(8'h05, 1, 0, 0, 0, "R9"); idle(4);
    go(8'hC3, 0, 0, 0, 0, "R2"); idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule